// File: doc/BRIEF.md
# Adaptive Contention Backoff Unit

This unit sits beside one core's cache controller and holds back that core's synchronization read misses while other cores are competing for the same synchronization data. Every remote synchronization read request that reaches the core is taken as a sign of contention. Each one adds the current increment to a backoff amount. After every N such requests, the increment itself is raised by a configured step. Contention that lasts therefore produces waits that grow faster and faster.

A local access is offered on a valid/go handshake and held until go is high. Only a synchronization read that misses is delayed: it waits as many cycles as the backoff amount held when it was first offered, and the backoff amount is then cleared for the next miss. Every other access is let through in the cycle it arrives. The controller has two named states. `BO_IDLE` accepts requests. `BO_WAIT` counts a delay down. The transition IDLE→WAIT is "take" (a delayable miss with a non-zero backoff). The transition WAIT→IDLE is "release" (the countdown has reached zero and go is given). The increment and the request counter return to their start values after `IDLE_LIMIT` cycles with no remote request.

Top module: `backoff_unit`

## Requirements
- R1: During synchronous active-low reset the backoff amount becomes 0, the remote counter becomes 0, and the increment is loaded from `cfg_step_i`; with no request offered, `req_go_o` and `stall_o` are 0.
- R2: Each cycle with `remote_req_i` high adds the current increment to the backoff amount.
- R3: A remote counter counts remote requests and wraps after `cfg_period_i` of them. On the wrapping request the increment grows by `cfg_step_i` in the same cycle, and the backoff update of that cycle uses the increment value from before the growth.
- R4: A synchronization read miss (`req_valid_i`, `req_sync_i` and `req_miss_i` all 1) offered in `BO_IDLE` while the backoff amount is b > 0 receives `req_go_o` exactly b cycles after its first cycle. `stall_o` is high in every cycle before that.
- R5: A synchronization read miss offered while the backoff amount is 0 receives `req_go_o` in the same cycle.
- R6: On take, the backoff amount is cleared, so a following miss with no remote request in between is granted at once.
- R7: Remote requests that arrive while a delay is being served accumulate into the backoff amount for the next miss, and they do not change the delay currently being served.
- R8: The backoff amount saturates at 2^BACKOFF_W−1 and does not wrap.
- R9: The increment saturates at 2^INCR_W−1 and does not wrap.
- R10: An access that is not a synchronization read miss (`req_sync_i`=0 or `req_miss_i`=0) is granted in the same cycle and leaves the backoff amount unchanged.
- R11: After `IDLE_LIMIT` consecutive cycles with no remote request, the increment is reloaded from `cfg_step_i` and the remote counter is cleared. The backoff amount is kept.
- R12: A `cfg_period_i` of 0 acts as 1: every remote request grows the increment.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| remote_req_i | input | 1 | One-cycle pulse per remote synchronization read request |
| req_valid_i | input | 1 | Local access offered; held until granted |
| req_sync_i | input | 1 | Offered access is a synchronization read |
| req_miss_i | input | 1 | Offered access misses in the local cache |
| cfg_step_i | input | INCR_W | Step added to the increment, and the increment's start value |
| cfg_period_i | input | PERIOD_W | Number of remote requests between increment steps |
| req_go_o | output | 1 | Offered access may issue this cycle |
| stall_o | output | 1 | Offered access is being held back |

## Verification
The checks take for granted that a local request, once offered, stays valid with unchanged attributes until it is granted. They also assume that the configuration inputs are stable from reset onward. The bench drives each request at a falling edge. It holds the request until go has been sampled high and the next rising edge has passed, and only then drops it. It changes the configuration only while reset is held. Remote pulses are driven one per cycle, during idle periods and during countdowns alike, so some remote requests coincide with the cycle in which the increment grows.

// File: rtl/bo_pkg.sv
package bo_pkg;
    typedef enum logic [0:0] {
        BO_IDLE = 1'b0,
        BO_WAIT = 1'b1
    } bo_state_e;
endpackage

// File: rtl/bo_tracker.sv
// Contention tracker: remote counter, adaptive increment, idle timeout.
module bo_tracker #(
    parameter int INCR_W     = 8,
    parameter int PERIOD_W   = 6,
    parameter int IDLE_LIMIT = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                remote_i,
    input  logic [INCR_W-1:0]   step_i,
    input  logic [PERIOD_W-1:0] period_i,
    output logic [INCR_W-1:0]   inc_o,
    output logic                wrap_o,
    output logic                idle_hit_o
);
    localparam int IDW = $clog2(IDLE_LIMIT + 1);
    localparam logic [IDW-1:0] IDLE_LAST = IDW'(IDLE_LIMIT - 1);

    logic [PERIOD_W-1:0] rcnt_q;
    logic [INCR_W-1:0]   inc_q;
    logic [IDW-1:0]      idle_q;
    logic [PERIOD_W:0]   rcnt_plus;
    logic [INCR_W:0]     inc_sum;
    logic [INCR_W-1:0]   inc_grown;

    always_comb begin
        rcnt_plus  = {1'b0, rcnt_q} + (PERIOD_W+1)'(1);
        // a period of zero wraps on every request, same as one
        wrap_o     = remote_i && (rcnt_plus >= {1'b0, period_i});
        inc_sum    = {1'b0, inc_q} + {1'b0, step_i};
        inc_grown  = inc_sum[INCR_W] ? {INCR_W{1'b1}} : inc_sum[INCR_W-1:0];
        idle_hit_o = !remote_i && (idle_q == IDLE_LAST);
        inc_o      = inc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcnt_q <= '0;
            inc_q  <= step_i;
            idle_q <= '0;
        end else if (remote_i) begin
            idle_q <= '0;
            if (wrap_o) begin
                rcnt_q <= '0;
                inc_q  <= inc_grown;
            end else begin
                rcnt_q <= rcnt_plus[PERIOD_W-1:0];
            end
        end else if (idle_hit_o) begin
            idle_q <= '0;
            rcnt_q <= '0;
            inc_q  <= step_i;
        end else begin
            idle_q <= idle_q + IDW'(1);
        end
    end
endmodule

// File: rtl/bo_accum.sv
// Backoff amount: saturating accumulation, cleared when a delay is taken.
module bo_accum #(
    parameter int BACKOFF_W = 12,
    parameter int INCR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 remote_i,
    input  logic                 take_i,
    input  logic [INCR_W-1:0]    inc_i,
    output logic [BACKOFF_W-1:0] b_o
);
    logic [BACKOFF_W-1:0] b_q;
    logic [BACKOFF_W:0]   b_sum;
    logic [BACKOFF_W-1:0] b_sat;

    always_comb begin
        b_sum = {1'b0, b_q} + (BACKOFF_W+1)'(inc_i);
        b_sat = b_sum[BACKOFF_W] ? {BACKOFF_W{1'b1}} : b_sum[BACKOFF_W-1:0];
        b_o   = b_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '0;
        end else if (take_i) begin
            b_q <= remote_i ? BACKOFF_W'(inc_i) : '0;
        end else if (remote_i) begin
            b_q <= b_sat;
        end
    end
endmodule

// File: rtl/bo_delay_fsm.sv
// Request controller: passes or delays local accesses.
module bo_delay_fsm
    import bo_pkg::*;
#(
    parameter int BACKOFF_W = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid_i,
    input  logic                 req_sync_i,
    input  logic                 req_miss_i,
    input  logic [BACKOFF_W-1:0] b_i,
    output logic                 go_o,
    output logic                 take_o,
    output bo_state_e            state_o,
    output logic [BACKOFF_W-1:0] cnt_o
);
    bo_state_e            state_q, state_d;
    logic [BACKOFF_W-1:0] cnt_q;
    logic                 delayable;
    logic                 b_nz;
    logic                 cnt_zero;

    assign delayable = req_valid_i && req_sync_i && req_miss_i;
    assign b_nz      = (b_i != '0);
    assign cnt_zero  = (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BO_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BO_IDLE: if (delayable && b_nz)         state_d = BO_WAIT;
            BO_WAIT: if (cnt_zero && req_valid_i)   state_d = BO_IDLE;
            default:                                state_d = BO_IDLE;
        endcase
    end

    always_comb begin
        go_o   = 1'b0;
        take_o = 1'b0;
        unique case (state_q)
            BO_IDLE: begin
                take_o = delayable && b_nz;
                go_o   = req_valid_i && !(delayable && b_nz);
            end
            BO_WAIT: go_o = req_valid_i && cnt_zero;
            default: go_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                            cnt_q <= '0;
        else if (take_o)                       cnt_q <= b_i - BACKOFF_W'(1);
        else if (state_q == BO_WAIT && !cnt_zero) cnt_q <= cnt_q - BACKOFF_W'(1);
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/backoff_unit.sv
module backoff_unit
    import bo_pkg::*;
#(
    parameter int BACKOFF_W  = 12,
    parameter int INCR_W     = 8,
    parameter int PERIOD_W   = 6,
    parameter int IDLE_LIMIT = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                remote_req_i,
    input  logic                req_valid_i,
    input  logic                req_sync_i,
    input  logic                req_miss_i,
    input  logic [INCR_W-1:0]   cfg_step_i,
    input  logic [PERIOD_W-1:0] cfg_period_i,
    output logic                req_go_o,
    output logic                stall_o
);
    logic [INCR_W-1:0]    inc_val;
    logic                 inc_wrap;
    logic                 idle_hit;
    logic [BACKOFF_W-1:0] b_val;
    logic                 take;
    bo_state_e            fsm_state;
    logic [BACKOFF_W-1:0] wait_cnt;

    bo_tracker #(
        .INCR_W(INCR_W), .PERIOD_W(PERIOD_W), .IDLE_LIMIT(IDLE_LIMIT)
    ) u_tracker (
        .clk(clk), .rst_n(rst_n), .remote_i(remote_req_i),
        .step_i(cfg_step_i), .period_i(cfg_period_i),
        .inc_o(inc_val), .wrap_o(inc_wrap), .idle_hit_o(idle_hit)
    );

    bo_accum #(
        .BACKOFF_W(BACKOFF_W), .INCR_W(INCR_W)
    ) u_accum (
        .clk(clk), .rst_n(rst_n), .remote_i(remote_req_i),
        .take_i(take), .inc_i(inc_val), .b_o(b_val)
    );

    bo_delay_fsm #(
        .BACKOFF_W(BACKOFF_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid_i),
        .req_sync_i(req_sync_i), .req_miss_i(req_miss_i), .b_i(b_val),
        .go_o(req_go_o), .take_o(take), .state_o(fsm_state), .cnt_o(wait_cnt)
    );

    assign stall_o = req_valid_i && !req_go_o;
endmodule

// File: rtl/bo_checker.sv
module bo_checker
    import bo_pkg::*;
#(
    parameter int BACKOFF_W = 12,
    parameter int INCR_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 remote,
    input logic                 req_valid,
    input logic                 req_sync,
    input logic                 req_miss,
    input logic                 go,
    input logic [INCR_W-1:0]    step,
    input logic [INCR_W-1:0]    inc,
    input logic                 idle_hit,
    input logic [BACKOFF_W-1:0] b_val,
    input logic                 take,
    input bo_state_e            state,
    input logic [BACKOFF_W-1:0] cnt
);
    a_r5_zero_backoff_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BO_IDLE && req_valid && req_sync && req_miss && b_val == '0) |-> go);

    a_r10_undelayed_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BO_IDLE && req_valid && !(req_sync && req_miss)) |-> (go && !take));

    a_r4_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BO_WAIT && cnt != '0) |=> (state == BO_WAIT && cnt == $past(cnt) - 1'b1));

    a_r4_no_early_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (state == BO_WAIT && cnt != '0) |-> !go);

    a_r6_clear_on_take: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (b_val == ($past(remote) ? BACKOFF_W'($past(inc)) : '0)));

    a_r8_backoff_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (remote && !take) |=> (b_val >= $past(b_val)));

    a_r9_incr_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        remote |=> (inc >= $past(inc)));

    a_r11_idle_reload: assert property (@(posedge clk) disable iff (!rst_n)
        idle_hit |=> (inc == $past(step)));

    a_in_request_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !go) |=> req_valid);
endmodule

bind backoff_unit bo_checker #(
    .BACKOFF_W(BACKOFF_W), .INCR_W(INCR_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .remote(remote_req_i), .req_valid(req_valid_i),
    .req_sync(req_sync_i), .req_miss(req_miss_i), .go(req_go_o),
    .step(cfg_step_i), .inc(inc_val), .idle_hit(idle_hit), .b_val(b_val),
    .take(take), .state(fsm_state), .cnt(wait_cnt)
);

// File: tb/tb_backoff_unit.sv
module tb_backoff_unit;
    localparam int BW = 12;
    localparam int IW = 8;
    localparam int PW = 6;
    localparam int IDLE = 64;

    typedef struct packed {
        logic [PW-1:0] period;
        logic [IW-1:0] step;
        logic [7:0]    pulses;
        logic [BW-1:0] delay;
    } vec_t;

    // R2 R3 R12 R5: pulses after reset, then the delay the next miss must see
    localparam vec_t VECS [8] = '{
        '{6'd4, 8'd2,  8'd1, 12'd2},
        '{6'd4, 8'd2,  8'd4, 12'd8},
        '{6'd4, 8'd2,  8'd6, 12'd16},
        '{6'd1, 8'd3,  8'd3, 12'd18},
        '{6'd2, 8'd5,  8'd5, 12'd45},
        '{6'd0, 8'd4,  8'd2, 12'd12},
        '{6'd3, 8'd1,  8'd0, 12'd0},
        '{6'd8, 8'd16, 8'd3, 12'd48}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic remote = 1'b0;
    logic req_valid = 1'b0;
    logic req_sync = 1'b0;
    logic req_miss = 1'b0;
    logic [IW-1:0] cfg_step = 8'd2;
    logic [PW-1:0] cfg_period = 6'd4;
    logic go, stall;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    backoff_unit #(.BACKOFF_W(BW), .INCR_W(IW), .PERIOD_W(PW), .IDLE_LIMIT(IDLE)) dut (
        .clk(clk), .rst_n(rst_n), .remote_req_i(remote), .req_valid_i(req_valid),
        .req_sync_i(req_sync), .req_miss_i(req_miss), .cfg_step_i(cfg_step),
        .cfg_period_i(cfg_period), .req_go_o(go), .stall_o(stall)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic [PW-1:0] n, input logic [IW-1:0] d);
        @(negedge clk);
        rst_n = 1'b0; cfg_period = n; cfg_step = d;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulses(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            remote = 1'b1;
        end
        @(negedge clk);
        remote = 1'b0;
    endtask

    // offer one access; count cycles to go; drive remotes in the first nrem wait cycles
    task automatic do_miss(input bit s, input bit m, input int nrem,
                           output int dly, output int stall_bad);
        bit got;
        @(negedge clk);
        req_valid = 1'b1; req_sync = s; req_miss = m;
        dly = 0; stall_bad = 0; got = 1'b0;
        while (!got) begin
            #1;
            if (go) got = 1'b1;
            else begin
                if (!stall) stall_bad++;
                @(negedge clk);
                dly++;
                remote = (dly <= nrem);
            end
        end
        @(posedge clk);
        #1;
        req_valid = 1'b0; remote = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int d, sb;
        // R1 reset state
        do_reset(6'd4, 8'd2);
        #1;
        check(go == 1'b0 && stall == 1'b0, "R1 idle outputs after reset", {go, stall}, 0);
        do_miss(1'b1, 1'b1, 0, d, sb);
        check(d == 0, "R1 backoff zero after reset", d, 0);

        // table walk: R2 R3 R4 R5 R12
        for (int v = 0; v < 8; v++) begin
            do_reset(VECS[v].period, VECS[v].step);
            pulses(int'(VECS[v].pulses));
            do_miss(1'b1, 1'b1, 0, d, sb);
            check(d == int'(VECS[v].delay), $sformatf("R2/R3 vector %0d delay", v), d, int'(VECS[v].delay));
            check(sb == 0, $sformatf("R4 vector %0d stall", v), sb, 0);
            // R6 cleared after take
            do_miss(1'b1, 1'b1, 0, d, sb);
            check(d == 0, $sformatf("R6 vector %0d follow-up", v), d, 0);
        end

        // R7 remotes during the wait go to the next miss
        do_reset(6'd4, 8'd2);
        pulses(2);
        do_miss(1'b1, 1'b1, 3, d, sb);
        check(d == 4, "R7 current delay unaffected", d, 4);
        do_miss(1'b1, 1'b1, 0, d, sb);
        check(d == 8, "R7 accumulated for next", d, 8);

        // R10 non-sync and hits pass, backoff kept
        do_reset(6'd4, 8'd2);
        pulses(4);
        do_miss(1'b0, 1'b1, 0, d, sb);
        check(d == 0, "R10 non-sync miss", d, 0);
        do_miss(1'b1, 1'b0, 0, d, sb);
        check(d == 0, "R10 sync hit", d, 0);
        do_miss(1'b0, 1'b0, 0, d, sb);
        check(d == 0, "R10 plain hit", d, 0);
        do_miss(1'b1, 1'b1, 0, d, sb);
        check(d == 8, "R10 backoff unchanged", d, 8);

        // R9 increment saturation: 200 + 255 + 255
        do_reset(6'd1, 8'd200);
        pulses(3);
        do_miss(1'b1, 1'b1, 0, d, sb);
        check(d == 710, "R9 increment saturates", d, 710);

        // R8 backoff saturation: 17 x 255 > 4095
        do_reset(6'd1, 8'd255);
        pulses(17);
        do_miss(1'b1, 1'b1, 0, d, sb);
        check(d == 4095, "R8 backoff saturates", d, 4095);
        check(sb == 0, "R4 stall during long wait", sb, 0);

        // R11 idle timeout reloads increment, keeps backoff
        do_reset(6'd2, 8'd2);
        pulses(2);
        repeat (IDLE + 6) @(negedge clk);
        pulses(1);
        do_miss(1'b1, 1'b1, 0, d, sb);
        check(d == 6, "R11 increment reloaded, backoff kept", d, 6);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule